// File: doc/BRIEF.md
# Framed serial data register with delay insertion

This block is the data register that sits between a JTAG TAP controller and a byte-level debug controller. It runs on the test clock and responds to capture, shift and update strobes that the TAP controller supplies. Each frame is nine bits long: eight data bits followed by one even-parity bit. Frames are shifted LSB first, so the data bits leave on TDO first and the parity bit leaves last. While one frame shifts out on TDO, the next frame shifts in from TDI.

In transmit mode, the controller offers a byte on a valid/acknowledge handshake, and a capture loads that byte together with its correct parity bit. If no byte is offered at capture, the register loads the delay byte 0xDB with a deliberately wrong parity bit. The remote side then sees a frame with no data in it, and the pending byte stays queued for a later capture. In both modes, the frame shifted in from TDI is examined at update. A frame with correct parity is presented as received data. A frame with wrong parity is reported as a parity error, and it is also reported as a break if its byte equals the break character.

Top module: `dr_frame_link`

## Requirements
- R1: With rst_n low at a rising TCK edge, every output is cleared: tx_ack, rx_valid, parity_err, break_det, rx_data, and TDO (the shift register is cleared).
- R2: On each rising edge with shift_dr high, the 9-bit register shifts right. TDI enters bit 8, and TDO always shows bit 0. A captured frame therefore leaves as data bit 0 through data bit 7, then the parity bit.
- R3: In transmit mode (tx_mode=1), a capture with tx_valid high loads tx_data into bits 7:0. It loads the even parity of that byte into bit 8, so the nine bits hold an even number of ones. tx_ack is high for exactly the one cycle after that capture edge.
- R4: In transmit mode, a capture with tx_valid low loads 0xDB with parity bit 1, which is a parity error. It gives no tx_ack. A byte offered at a later capture is then loaded normally, so it is not lost.
- R5: On update_dr, a frame whose bit 8 equals the even parity of bits 7:0 is copied to rx_data, and rx_valid is high for the single following cycle.
- R6: On update_dr, a frame with a parity mismatch raises parity_err for one cycle. It does not raise rx_valid, and it leaves rx_data unchanged.
- R7: A parity-failing frame whose byte equals BREAK_CHAR (default 0xBB) also raises break_det in the same cycle. A parity-failing frame with any other byte raises parity_err alone.
- R8: A frame holding 0xBB with correct parity (bit 8 = 0) is ordinary data: rx_valid is raised and break_det is not.
- R9: In receive mode (tx_mode=0), a capture loads all zeros, gives no tx_ack and ignores tx_valid. Frame checking at update works as in transmit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, register bit 0 |
| tx_valid | input | 1 | A byte to send is pending |
| tx_data | input | 8 | Byte to send |
| tx_ack | output | 1 | One-cycle pulse: pending byte was captured |
| rx_data | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data was just updated |
| parity_err | output | 1 | One-cycle pulse: updated frame failed parity |
| break_det | output | 1 | One-cycle pulse: failing frame was the break character |

## Verification
Random rounds mix transmit and receive modes and present or withhold a pending byte. Each round also chooses between correct and corrupted incoming parity, and sometimes forces the byte to the break character. This separates three outcomes: a correct byte load, a delay substitution, and an all-zero receive capture. On the update side, it separates valid data, a plain parity error and a break.

Directed cases cover four points:
- a delay capture followed by a real capture of the same byte, to show the byte stays queued;
- 0xBB with correct parity, which must be data and not a break;
- a bad-parity byte other than 0xBB, which must raise the error without the break;
- tx_valid held high in receive mode, to show it is ignored.

// File: rtl/dr_frame_pkg.sv
// Package: shared constants and helpers for the framed data register.
// Assumes frames are one data byte plus one trailing even-parity bit.
package dr_frame_pkg;

    // Outcome of examining a received frame at update.
    typedef enum logic [1:0] {
        FV_GOOD   = 2'd0,
        FV_PARITY = 2'd1,
        FV_BREAK  = 2'd2
    } frame_verdict_t;

    // Even parity bit: makes the total count of ones even.
    function automatic logic even_par8(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/dr_tx_loader.sv
// Module: dr_tx_loader
// Chooses the value that a capture loads into the shift register, and
// acknowledges a pending transmit byte when that byte is taken.
// Assumes capture_dr is a one-cycle strobe. Also assumes tx_valid holds
// until tx_ack is seen.
module dr_tx_loader #(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  DELAY_CHAR = 8'hDB,
    localparam int         FRAME_W    = DATA_W + 1
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               capture_dr,
    input  logic               tx_mode,
    input  logic               tx_valid,
    input  logic [DATA_W-1:0]  tx_data,
    output logic [FRAME_W-1:0] load_frame,
    output logic               tx_ack
);

    logic take_byte;

    // Purpose: decide whether this capture consumes the pending byte.
    always_comb take_byte = capture_dr && tx_mode && tx_valid;

    // Purpose: build the capture value (real byte, delay marker, or zero).
    always_comb begin
        if (!tx_mode)
            load_frame = '0;
        else if (tx_valid)
            load_frame = {^tx_data, tx_data};
        else
            load_frame = {~(^DELAY_CHAR[DATA_W-1:0]), DELAY_CHAR[DATA_W-1:0]};
    end

    // Purpose: one-cycle acknowledge after the byte is captured.
    always_ff @(posedge tck) begin
        if (!rst_n)
            tx_ack <= 1'b0;
        else
            tx_ack <= take_byte;
    end

endmodule

// File: rtl/dr_shift_reg.sv
// Module: dr_shift_reg
// Nine-bit capture/shift register. It shifts right, takes TDI into the
// top bit, and drives TDO from bit 0.
// Assumes capture_dr and shift_dr are never high together; capture wins.
module dr_shift_reg #(
    parameter int  DATA_W  = 8,
    localparam int FRAME_W = DATA_W + 1
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               tdi,
    input  logic [FRAME_W-1:0] load_frame,
    output logic [FRAME_W-1:0] frame_q,
    output logic               tdo
);

    // Purpose: load on capture, shift toward bit 0 on shift.
    always_ff @(posedge tck) begin
        if (!rst_n)
            frame_q <= '0;
        else if (capture_dr)
            frame_q <= load_frame;
        else if (shift_dr)
            frame_q <= {tdi, frame_q[FRAME_W-1:1]};
    end

    // Purpose: serial output is the lowest register bit.
    always_comb tdo = frame_q[0];

endmodule

// File: rtl/dr_rx_checker.sv
// Module: dr_rx_checker
// Examines the shifted-in frame on update. It passes good bytes on, and
// classifies parity failures as either plain errors or breaks.
// Assumes update_dr is a one-cycle strobe. All outputs are one-cycle
// pulses except rx_data, which holds the last good byte.
module dr_rx_checker
    import dr_frame_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  BREAK_CHAR = 8'hBB,
    localparam int         FRAME_W    = DATA_W + 1
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               update_dr,
    input  logic [FRAME_W-1:0] frame_q,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               parity_err,
    output logic               break_det
);

    frame_verdict_t verdict;

    // Purpose: classify the frame now held in the register.
    always_comb begin
        if ((^frame_q[DATA_W-1:0]) == frame_q[FRAME_W-1])
            verdict = FV_GOOD;
        else if (frame_q[DATA_W-1:0] == BREAK_CHAR[DATA_W-1:0])
            verdict = FV_BREAK;
        else
            verdict = FV_PARITY;
    end

    // Purpose: register the verdict as pulses and latch good bytes.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            break_det  <= 1'b0;
        end else begin
            rx_valid   <= update_dr && (verdict == FV_GOOD);
            parity_err <= update_dr && (verdict != FV_GOOD);
            break_det  <= update_dr && (verdict == FV_BREAK);
            if (update_dr && verdict == FV_GOOD)
                rx_data <= frame_q[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/dr_frame_link.sv
// Module: dr_frame_link (top)
// Framed serial data register: capture/shift/update from a TAP
// controller, delay-marker insertion on transmit, and parity and break
// checking on receive.
// Assumes the TAP strobes are mutually exclusive one-cycle pulses on TCK.
module dr_frame_link #(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  BREAK_CHAR = 8'hBB,
    parameter logic [7:0]  DELAY_CHAR = 8'hDB,
    localparam int         FRAME_W    = DATA_W + 1
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              break_det
);

    logic [FRAME_W-1:0] load_frame;
    logic [FRAME_W-1:0] frame_q;

    dr_tx_loader #(.DATA_W(DATA_W), .DELAY_CHAR(DELAY_CHAR)) u_loader (
        .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .tx_mode(tx_mode),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .load_frame(load_frame), .tx_ack(tx_ack)
    );

    dr_shift_reg #(.DATA_W(DATA_W)) u_sreg (
        .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .tdi(tdi), .load_frame(load_frame), .frame_q(frame_q), .tdo(tdo)
    );

    dr_rx_checker #(.DATA_W(DATA_W), .BREAK_CHAR(BREAK_CHAR)) u_rx (
        .tck(tck), .rst_n(rst_n), .update_dr(update_dr), .frame_q(frame_q),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .parity_err(parity_err), .break_det(break_det)
    );

endmodule

// File: rtl/dr_frame_link_chk.sv
// Module: dr_frame_link_chk
// Property checker bound to dr_frame_link.
module dr_frame_link_chk #(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  DELAY_CHAR = 8'hDB,
    localparam int         FRAME_W    = DATA_W + 1
) (
    input logic               tck,
    input logic               rst_n,
    input logic               tx_mode,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic               tx_valid,
    input logic               tdo,
    input logic               tx_ack,
    input logic               rx_valid,
    input logic               parity_err,
    input logic               break_det,
    input logic [FRAME_W-1:0] frame_q
);

    a_r2_shift_out: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_dr && !capture_dr) |=> (tdo == $past(frame_q[1])));

    a_r3_ack_source: assert property (@(posedge tck) disable iff (!rst_n)
        tx_ack |-> $past(capture_dr && tx_mode && tx_valid));

    a_r4_delay_marker: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_dr && tx_mode && !tx_valid) |=>
            (frame_q == {~(^DELAY_CHAR[DATA_W-1:0]), DELAY_CHAR[DATA_W-1:0]} && !tx_ack));

    a_r5_valid_after_update: assert property (@(posedge tck) disable iff (!rst_n)
        rx_valid |-> $past(update_dr));

    a_r6_err_excludes_valid: assert property (@(posedge tck) disable iff (!rst_n)
        !(rx_valid && parity_err));

    a_r7_break_needs_err: assert property (@(posedge tck) disable iff (!rst_n)
        break_det |-> parity_err);

    a_r9_rx_capture_zero: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_dr && !tx_mode) |=> (frame_q == '0 && !tx_ack));

endmodule

bind dr_frame_link dr_frame_link_chk #(.DATA_W(DATA_W), .DELAY_CHAR(DELAY_CHAR)) u_chk (
    .tck(tck), .rst_n(rst_n), .tx_mode(tx_mode), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tx_valid(tx_valid), .tdo(tdo),
    .tx_ack(tx_ack), .rx_valid(rx_valid), .parity_err(parity_err),
    .break_det(break_det), .frame_q(frame_q)
);

// File: tb/dr_frame_link_bench.sv
module dr_frame_link_bench;
    localparam int CLK_PERIOD = 10;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_mode = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic       tdi = 1'b0, tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tdo, tx_ack, rx_valid, parity_err, break_det;
    logic [7:0] rx_data;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 0;
    logic [7:0] last_rx = 8'h00;

    dr_frame_link u_dr_frame_link (
        .tck(tck), .rst_n(rst_n), .tx_mode(tx_mode), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ack(tx_ack),
        .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
        .break_det(break_det)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    function automatic logic [8:0] good_frame(input logic [7:0] b);
        return {^b, b};
    endfunction

    // Expected capture value per R3, R4, R9
    function automatic logic [8:0] exp_capture(input logic mode, input logic v, input logic [7:0] b);
        if (!mode) return 9'h000;
        if (v) return good_frame(b);
        return 9'h1DB;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_capture(input logic exp_ack, input string req);
        capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0;
        chk(req, tx_ack, exp_ack);
        if (tx_ack) tx_valid = 1'b0;
        @(negedge tck);
        chk(req, tx_ack, 1'b0);
    endtask

    // Shift 9 bits in, comparing TDO to the captured frame (R2)
    task automatic shift_frame(input logic [8:0] in_f, input logic [8:0] out_f, input string req);
        for (int i = 0; i < 9; i++) begin
            chk(req, tdo, out_f[i]);
            shift_dr = 1'b1;
            tdi = in_f[i];
            @(negedge tck);
        end
        shift_dr = 1'b0;
    endtask

    // Update and check verdict outputs per R5..R8
    task automatic do_update(input logic [8:0] f, input string req);
        logic good, brk;
        good = (^f[7:0]) == f[8];
        brk  = !good && (f[7:0] == 8'hBB);
        if (good) last_rx = f[7:0];
        update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0;
        chk(req, rx_valid, good);
        chk(req, parity_err, !good);
        chk(req, break_det, brk);
        chk(req, rx_data, last_rx);
        @(negedge tck);
        chk(req, rx_valid | parity_err | break_det, 1'b0);
    endtask

    task automatic round(input logic mode, input logic [8:0] in_f, input string req);
        logic [8:0] exp_f;
        logic took;
        tx_mode = mode;
        exp_f = exp_capture(mode, tx_valid, tx_data);
        took = mode && tx_valid;
        do_capture(took, req);
        shift_frame(in_f, exp_f, req);
        do_update(in_f, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] b;
        logic bad;
        seed = 32'h1d5;
        void'($urandom(seed));
        repeat (3) @(negedge tck);
        // R1: reset state
        chk("R1", {tdo, tx_ack, rx_valid, parity_err, break_det}, 5'b0);
        chk("R1", rx_data, 8'h00);
        rst_n = 1'b1;
        @(negedge tck);

        // R4: delay then real byte of the same pending request
        tx_data = 8'h3C;
        tx_mode = 1'b1;
        round(1'b1, good_frame(8'h11), "R4");
        tx_valid = 1'b1;
        round(1'b1, good_frame(8'h22), "R3");
        chk("R4", tx_valid, 1'b0);
        // R9: receive-mode capture ignores tx_valid
        tx_valid = 1'b1; tx_data = 8'hA5;
        round(1'b0, good_frame(8'h5A), "R9");
        chk("R9", tx_valid, 1'b1);
        round(1'b1, good_frame(8'h01), "R3");
        // R8: 0xBB with good parity is data
        round(1'b0, 9'h0BB, "R8");
        // R7: 0xBB bad parity is a break; other bad byte is not
        round(1'b0, 9'h1BB, "R7");
        round(1'b1, {~(^8'h5A), 8'h5A}, "R7");
        // R6: error leaves rx_data
        round(1'b0, {~(^8'hF0), 8'hF0}, "R6");

        // Random rounds: R2, R3, R5, R6
        for (int n = 0; n < 60; n++) begin
            if (!tx_valid && ($urandom % 2)) begin
                tx_valid = 1'b1;
                tx_data = 8'($urandom);
            end
            b = 8'($urandom);
            if ($urandom % 5 == 0) b = 8'hBB;
            bad = ($urandom % 3 == 0);
            round(1'($urandom), {(^b) ^ bad, b}, bad ? "R6" : "R5");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule